// File: doc/BRIEF.md
# PDM Microphone Bit-Clock Generator

This block derives the bit clock for up to several pulse-density-modulated microphones from a fast system clock. Two integer divide ratios are fixed at build time: one for the normal-power rate and one for the low-power rate. A one-bit rate request picks between them. Because the microphone infers its power mode from the incoming clock rate, this request is in effect the power-mode control for every attached microphone.

A rate change never shortens the period in progress. The new ratio is loaded only when a period ends and the clock is low. A rate change may upset the microphones for a while, so a registered mute flag goes high as soon as the request differs from the rate in use. The flag stays high until a programmable number of full output periods have run at the new rate. Downstream audio logic blanks its samples while the flag is high.

Each microphone receives its own gated copy of the clock. Its enable is captured only while the clock is low, so enabling or disabling a microphone never creates a short pulse. Two one-cycle strobes mark the system-clock cycles in which the bit clock rises and falls, so that capture logic can sample the shared data line on the correct edge.

Top module: `pdm_clkgen`

## Requirements
- R1: While `rst` is high, every `pdm_clk` bit, `mute`, `rise_stb` and `fall_stb` are 0. The rate in use is set to the rate requested during reset.
- R2: With `mode_lp` = 0 (normal power), the bit clock period is `DIV_NORMAL` system cycles.
- R3: With `mode_lp` = 1 (low power), the bit clock period is `DIV_LOW` system cycles.
- R4: The bit clock is high for exactly half its period. An odd ratio N gives N half-cycles of the system clock high out of 2N.
- R5: `rise_stb` is high for one system cycle per period: the first cycle of the high phase. `fall_stb` is high for one system cycle per period: the cycle in which the clock falls. The two strobes are never high together.
- R6: A new rate takes effect only at the start of a period. The period running when the request changes completes at the old ratio.
- R7: `mute` goes high one system cycle after `mode_lp` differs from the rate in use.
- R8: After a switch, `mute` stays high through `MUTE_CYC` complete periods at the new rate, then drops. If the request changes right after a rising strobe, `mute` is high for (old ratio + `MUTE_CYC` × new ratio) cycles.
- R9: If the request returns to the rate in use before a period boundary, no switch occurs. The period is unchanged, and `mute` is high for exactly one cycle per cycle of difference.
- R10: A microphone whose `mic_en` bit is 0 receives a constant-low clock. The other microphones are unaffected.
- R11: A change of a `mic_en` bit while the clock is high has no effect on that microphone's output until the next low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_lp | input | 1 | Rate request: 1 selects the low-power rate, 0 selects the normal rate |
| mic_en | input | NUM_MICS | Per-microphone clock enable |
| pdm_clk | output | NUM_MICS | Gated bit clock, one per microphone |
| mute | output | 1 | High while a rate change is pending or settling |
| rise_stb | output | 1 | One-cycle strobe in the cycle the bit clock rises |
| fall_stb | output | 1 | One-cycle strobe in the cycle the bit clock falls |

## Verification
The rate switch and the rising strobe of the first new period fall in the same system cycle. In that cycle the mute timer is also loaded, so that rising edge must not be counted as one of the settling periods. The bench changes the request just after a rising strobe. It then checks three things: the next rising strobe arrives after the old ratio, the following one arrives after the new ratio, and the mute length equals the old ratio plus `MUTE_CYC` new periods. A second case changes the request and restores it within one period. It checks for a one-cycle mute with no change of period.

// File: rtl/pdmck_pkg.sv
package pdmck_pkg;
  typedef enum logic {
    RATE_NORMAL = 1'b0,
    RATE_LOW    = 1'b1
  } rate_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pdmck_divider.sv
module pdmck_divider
  import pdmck_pkg::*;
#(
  parameter int unsigned DIV_NORMAL = 16,
  parameter int unsigned DIV_LOW    = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  rate_e rate_req,
  output logic  base_clk,
  output logic  rise_stb,
  output logic  fall_stb,
  output logic  switch_stb,
  output rate_e rate_now
);
  localparam int unsigned DIV_MAX = max_u(DIV_NORMAL, DIV_LOW);
  localparam int unsigned CW      = $clog2(DIV_MAX + 1);
  localparam bit          ANY_ODD = (DIV_NORMAL % 2 == 1) || (DIV_LOW % 2 == 1);

  logic [CW-1:0] cnt_q, div_q;
  logic [CW-1:0] div_sel, div_n, cnt_n, half_n;
  logic          wrap;
  logic          hi_q;
  rate_e         rate_q;

  assign div_sel = (rate_req == RATE_LOW) ? CW'(DIV_LOW) : CW'(DIV_NORMAL);

  // a period ends on its last low cycle; only there may the ratio change
  always_comb begin
    wrap   = (cnt_q == div_q - CW'(1));
    div_n  = wrap ? div_sel : div_q;
    cnt_n  = wrap ? '0 : cnt_q + CW'(1);
    half_n = div_n >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= div_sel - CW'(1);
      div_q      <= div_sel;
      rate_q     <= rate_req;
      hi_q       <= 1'b0;
      rise_stb   <= 1'b0;
      fall_stb   <= 1'b0;
      switch_stb <= 1'b0;
    end else begin
      cnt_q      <= cnt_n;
      div_q      <= div_n;
      if (wrap) rate_q <= rate_req;
      hi_q       <= (cnt_n < half_n);
      rise_stb   <= (cnt_n == '0);
      fall_stb   <= (cnt_n == half_n);
      switch_stb <= wrap && (rate_req != rate_q);
    end
  end

  assign rate_now = rate_q;

  generate
    if (ANY_ODD) begin : g_odd
      // half-cycle tail stretches the high phase of an odd ratio to N/2
      logic tail_q;
      always_ff @(negedge clk) begin
        if (rst) tail_q <= 1'b0;
        else     tail_q <= hi_q;
      end
      assign base_clk = hi_q | (tail_q & div_q[0]);
    end else begin : g_even
      assign base_clk = hi_q;
    end
  endgenerate
endmodule

// File: rtl/pdmck_mute.sv
module pdmck_mute #(
  parameter int unsigned MUTE_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic switch_stb,
  input  logic rise_stb,
  output logic mute
);
  localparam int unsigned TW = $clog2(MUTE_CYC + 1);

  logic [TW-1:0] left_q, left_n;

  // the switch cycle is itself a rising edge; loading wins over counting
  always_comb begin
    left_n = left_q;
    if (switch_stb)                    left_n = TW'(MUTE_CYC);
    else if (rise_stb && left_q != '0) left_n = left_q - TW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      mute   <= 1'b0;
    end else begin
      left_q <= left_n;
      mute   <= pending || (left_n != '0);
    end
  end
endmodule

// File: rtl/pdmck_gate.sv
module pdmck_gate (
  input  logic base_clk,
  input  logic en,
  output logic gclk
);
  logic en_l;

  // enable may only move while the clock is low
  always_latch begin
    if (!base_clk) en_l = en;
  end

  assign gclk = base_clk & en_l;
endmodule

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
  import pdmck_pkg::*;
#(
  parameter int unsigned NUM_MICS   = 2,
  parameter int unsigned DIV_NORMAL = 16,
  parameter int unsigned DIV_LOW    = 64,
  parameter int unsigned MUTE_CYC   = 1024
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_lp,
  input  logic [NUM_MICS-1:0] mic_en,
  output logic [NUM_MICS-1:0] pdm_clk,
  output logic                mute,
  output logic                rise_stb,
  output logic                fall_stb
);
  rate_e rate_req, applied_rate;
  logic  base_clk, switch_stb, pending;

  assign rate_req = mode_lp ? RATE_LOW : RATE_NORMAL;
  assign pending  = (rate_req != applied_rate);

  pdmck_divider #(
    .DIV_NORMAL(DIV_NORMAL),
    .DIV_LOW   (DIV_LOW)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .rate_req  (rate_req),
    .base_clk  (base_clk),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .switch_stb(switch_stb),
    .rate_now  (applied_rate)
  );

  pdmck_mute #(
    .MUTE_CYC(MUTE_CYC)
  ) u_mute (
    .clk       (clk),
    .rst       (rst),
    .pending   (pending),
    .switch_stb(switch_stb),
    .rise_stb  (rise_stb),
    .mute      (mute)
  );

  generate
    for (genvar i = 0; i < NUM_MICS; i++) begin : g_mic
      pdmck_gate u_gate (
        .base_clk(base_clk),
        .en      (mic_en[i]),
        .gclk    (pdm_clk[i])
      );
    end
  endgenerate
endmodule

// File: rtl/pdm_clkgen_chk.sv
module pdm_clkgen_chk #(
  parameter int unsigned NUM_MICS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                mode_lp,
  input logic [NUM_MICS-1:0] pdm_clk,
  input logic                mute,
  input logic                rise_stb,
  input logic                fall_stb,
  input logic                base_clk,
  input logic                applied
);
  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rise_stb && fall_stb)); // R5

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
    rise_stb |=> !rise_stb); // R5

  AST_SWITCH_AT_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && applied != $past(applied)) |-> rise_stb); // R6

  AST_MUTE_ON_REQ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_lp != $past(mode_lp) && mode_lp != applied) |=> mute); // R7

  AST_MUTE_AT_SWITCH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && applied != $past(applied)) |-> mute); // R8

  AST_GATE_LOW: assert property (@(posedge clk) disable iff (rst)
    (pdm_clk & ~{NUM_MICS{base_clk}}) == '0); // R10
endmodule

bind pdm_clkgen pdm_clkgen_chk #(.NUM_MICS(NUM_MICS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mode_lp (mode_lp),
  .pdm_clk (pdm_clk),
  .mute    (mute),
  .rise_stb(rise_stb),
  .fall_stb(fall_stb),
  .base_clk(base_clk),
  .applied (applied_rate)
);

// File: tb/pdm_clkgen_bench.sv
module pdm_clkgen_bench;
  localparam int NM = 2;
  localparam int DN = 5;
  localparam int DL = 8;
  localparam int MC = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mode_lp = 1'b0;
  logic [NM-1:0] mic_en = 2'b11;
  logic [NM-1:0] pdm_clk;
  logic          mute, rise_stb, fall_stb;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pdm_clkgen #(
    .NUM_MICS(NM), .DIV_NORMAL(DN), .DIV_LOW(DL), .MUTE_CYC(MC)
  ) u_pdm_clkgen (
    .clk(clk), .rst(rst), .mode_lp(mode_lp), .mic_en(mic_en),
    .pdm_clk(pdm_clk), .mute(mute), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  typedef struct packed {
    logic       lp;
    logic [7:0] per;
    logic [7:0] hi;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 8'(DN), 8'(DN)},
    '{1'b1, 8'(DL), 8'(DL)},
    '{1'b0, 8'(DN), 8'(DN)},
    '{1'b0, 8'(DN), 8'(DN)},
    '{1'b1, 8'(DL), 8'(DL)},
    '{1'b1, 8'(DL), 8'(DL)}
  };

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic sync_rise();
    int guard = 0;
    do begin
      step();
      guard++;
    end while (!rise_stb && guard < 400);
  endtask

  task automatic wait_unmuted();
    int guard = 0;
    while (mute && guard < 400) begin
      step();
      guard++;
    end
  endtask

  // one period from a rising strobe; counts half-cycle samples of each clock
  task automatic measure(output int per, output int hi0, output int hi1,
                         output int nfall, output int both);
    sync_rise();
    per = 0; hi0 = 0; hi1 = 0; nfall = 0; both = 0;
    do begin
      if (rise_stb && fall_stb) both++;
      if (fall_stb) nfall++;
      hi0 += int'(pdm_clk[0]);
      hi1 += int'(pdm_clk[1]);
      #10;
      hi0 += int'(pdm_clk[0]);
      hi1 += int'(pdm_clk[1]);
      #10;
      per++;
    end while (!rise_stb && per < 200);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int per, hi0, hi1, nf, both, cnt;

    // R1: state held in reset
    for (int i = 0; i < 4; i++) begin
      step();
      check_eq("R1 pdm_clk in reset", int'(pdm_clk), 0);
      check_eq("R1 mute in reset", int'(mute), 0);
      check_eq("R1 strobes in reset", int'(rise_stb) + int'(fall_stb), 0);
    end
    rst = 1'b0;

    // R2 R3 R4 R5: table walk
    foreach (VEC[i]) begin
      mode_lp = VEC[i].lp;
      step();
      wait_unmuted();
      measure(per, hi0, hi1, nf, both);
      check_eq(VEC[i].lp ? "R3 period low rate" : "R2 period normal rate", per, int'(VEC[i].per));
      check_eq("R4 high half-cycles", hi0, int'(VEC[i].hi));
      check_eq("R5 one fall strobe", nf, 1);
      check_eq("R5 strobes exclusive", both, 0);
    end

    // R6 R7 R8: normal to low
    mode_lp = 1'b0;
    step(); wait_unmuted();
    sync_rise();
    mode_lp = 1'b1;
    step();
    check_eq("R7 mute one cycle after request", int'(mute), 1);
    cnt = 1; per = 1;
    while (!rise_stb && per < 100) begin step(); per++; cnt += int'(mute); end
    check_eq("R6 old period finishes", per, DN);
    while (mute && cnt < 400) begin step(); cnt += int'(mute); end
    check_eq("R8 mute length to low", cnt, DN + MC * DL);

    // R8 low to normal, checked via the next period as well
    sync_rise();
    mode_lp = 1'b0;
    step();
    check_eq("R7 mute on return", int'(mute), 1);
    cnt = 1;
    while (mute && cnt < 400) begin step(); cnt += int'(mute); end
    check_eq("R8 mute length to normal", cnt, DL + MC * DN);
    measure(per, hi0, hi1, nf, both);
    check_eq("R2 period after switch", per, DN);

    // R9: request flips and returns inside one period
    sync_rise();
    mode_lp = 1'b1;
    step();
    mode_lp = 1'b0;
    check_eq("R9 brief mute", int'(mute), 1);
    step();
    check_eq("R9 mute released", int'(mute), 0);
    per = 2;
    while (!rise_stb && per < 100) begin step(); per++; end
    check_eq("R9 period unchanged", per, DN);
    measure(per, hi0, hi1, nf, both);
    check_eq("R9 next period unchanged", per, DN);

    // R10: one microphone disabled
    mic_en = 2'b01;
    sync_rise();
    measure(per, hi0, hi1, nf, both);
    check_eq("R10 disabled mic stays low", hi1, 0);
    check_eq("R10 enabled mic runs", hi0, DN);

    // R11: enable raised while high
    sync_rise();
    mic_en = 2'b11;
    #1;
    check_eq("R11 late enable ignored", int'(pdm_clk[1]), 0);
    #19;
    check_eq("R11 late enable still ignored", int'(pdm_clk[1]), 0);
    sync_rise();
    check_eq("R11 enable applied next period", int'(pdm_clk[1]), 1);

    // R11: enable dropped while high
    mic_en = 2'b01;
    #1;
    check_eq("R11 late disable no truncation", int'(pdm_clk[1]), 1);
    #19;
    check_eq("R11 late disable holds high", int'(pdm_clk[1]), 1);
    sync_rise();
    check_eq("R11 disable applied next period", int'(pdm_clk[1]), 0);
    check_eq("R10 neighbour unaffected", int'(pdm_clk[0]), 1);

    finish_run();
  end
endmodule